// File: doc/BRIEF.md
# Battery-Backed Key Register Controller

This block guards a nine-word key store of 32-bit values. Software reaches it through a plain register bus: one cycle per access, with write and read strobes, a byte address and write data. Read data and an error flag come back one clock later. A wait flag tells the master to hold off key-related writes. The key words are plain flops. A dedicated vault reset clears them. The ordinary soft reset leaves them untouched, so a key survives while every control and status field returns to its reset value.

The key can only be loaded after programming mode has been entered with a magic word. Entering that mode also wipes the store. Once loaded, the key is never readable. Software proves that it loaded the key correctly by writing an expected CRC. A small serial engine then folds a zero word followed by key words 0 to 7 through CRC-32C, one word per clock, and records whether the result matched.

The ninth word is special in two ways. It can be frozen by a sticky lock bit. Alternatively, a build option makes it write-only, in which case it is also wiped by zeroization and can never be locked. An unmapped access can be reported as a bus error and as a maskable interrupt.

Top module: `keyvault_ctrl`

## Requirements
- R1: After reset the register reads are as follows. Status (0x00) reads 0, the lock register (0x4C) reads 0 and the interrupt mask (0x3C) reads 1. The interrupt and wait outputs are low.
- R2: Writing exactly 0x757BDF0D to the mode register (0x08) sets status bit 0 (programming mode) and zeroizes the store. Any other value has no effect. Bit 0 then stays set through further mode-register writes and clears only on reset.
- R3: Writing 1 in bit 0 of the control register (0x04) zeroizes the store. The control register always reads 0.
- R4: Zeroization does the following:
  - It clears key words 0 to 7.
  - It sets status bit 4 (zeroized).
  - It clears key word 8 only when the write-only option is on; otherwise word 8 keeps its value.
- R5: Key words 0 to 7 (0x10 to 0x2C) and the CRC register (0x0C) always read 0. Writes to key words 0 to 7 are ignored outside programming mode.
- R6: An accepted write of a nonzero value to a key word clears status bit 4. A write to word 8 (0x30) counts for this only when the write-only option is on.
- R7: Word 8 takes a write only while programming mode is on and the lock bit is 0. It reads back its value, or 0 when the write-only option is on.
- R8: Writing 1 to bit 0 of the lock register sets it, and only reset clears it. With the write-only option on, the bit never sets.
- R9: A CRC-register write in programming mode raises the wait output for 9 cycles. At the end, status bit 8 (done) is set, and status bit 9 (pass) is set when the written value equals the CRC of a zero word followed by words 0 to 7. The CRC is reflected CRC-32C: polynomial 0x82F63B78, initial value 0, no final inversion, each word taken LSB first. Outside programming mode such a write does nothing.
- R10: While the wait output is high, writes to the control, mode, CRC and key registers are not performed.
- R11: Any access to an unmapped or unaligned address has an effect only when bit 0 of the error-enable register (0x34) is 1. In that case it returns the error flag with the read-data cycle and sets bit 0 of the interrupt status register (0x38). With the enable at 0, it does neither.
- R12: The interrupt status bit is write-one-to-clear. The mask register is read-only. Writing 1 to bit 0 of 0x40 clears the mask, and writing 1 to bit 0 of 0x44 sets it. The interrupt output equals status AND NOT mask, one cycle later.
- R13: The status register ignores bus writes. A soft reset restores every non-key register but keeps the key words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high soft reset, key words excluded |
| vault_rst | input | 1 | Synchronous active-high reset of the key words |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| bus_err_o | output | 1 | Error flag, one cycle after an unmapped access |
| bus_wait_o | output | 1 | High while the integrity check runs |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the modes that a naive register file gets wrong:
- Word 8 survives control-driven zeroization when the write-only option is off. A design that always wiped it would read back 0.
- A zero write, or a word-8 write in readable mode, leaves the zeroized flag set. A design that cleared it on any write would show bit 4 low.
- The lock and the programming mode stay set against writes of 0. A design without stickiness would let word 8 change after locking.
- The integrity check is timed and checked for both a matching and a mismatching expected value, and a key write is attempted while the check runs. A design that let the write through would show a changed word 8. A design that ran the check outside programming mode would raise the wait output.

// File: rtl/kv_pkg.sv
package kv_pkg;
  localparam int unsigned BKV_W     = 32;
  localparam int unsigned KEY_WORDS = 9;
  localparam int unsigned CHK_WORDS = KEY_WORDS - 1;
  localparam int unsigned KIDX_W    = $clog2(KEY_WORDS);

  // word offsets (byte address / 4); software depends on these
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_CTRL   = 1;
  localparam int unsigned OFS_MODE   = 2;
  localparam int unsigned OFS_CRC    = 3;
  localparam int unsigned OFS_KEY0   = 4;
  localparam int unsigned OFS_ERREN  = OFS_KEY0 + KEY_WORDS;
  localparam int unsigned OFS_ISR    = OFS_ERREN + 1;
  localparam int unsigned OFS_IMR    = OFS_ERREN + 2;
  localparam int unsigned OFS_IEN    = OFS_ERREN + 3;
  localparam int unsigned OFS_IDIS   = OFS_ERREN + 4;
  localparam int unsigned OFS_LOCK   = OFS_ERREN + 6;

  // status bit positions
  localparam int unsigned ST_MODE = 0;
  localparam int unsigned ST_ZERO = 4;
  localparam int unsigned ST_DONE = 8;
  localparam int unsigned ST_PASS = 9;

  typedef logic [BKV_W-1:0] word_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STATUS, SEL_CTRL, SEL_MODE, SEL_CRC, SEL_KEY,
    SEL_ERREN, SEL_ISR, SEL_IMR, SEL_IEN, SEL_IDIS, SEL_LOCK
  } sel_e;

  typedef struct packed {
    sel_e              sel;
    logic [KIDX_W-1:0] key_idx;
  } dec_t;

  // reflected CRC over one word, least significant bit first
  function automatic word_t crc_fold(word_t crc_in, word_t data, word_t poly);
    word_t c;
    logic  fb;
    c = crc_in;
    for (int b = 0; b < BKV_W; b++) begin
      fb = c[0] ^ data[b];
      c  = c >> 1;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/kv_decode.sv
module kv_decode
  import kv_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  assign widx = addr_i[ADDR_W-1:2];

  always_comb begin
    dec_o.sel     = SEL_NONE;
    dec_o.key_idx = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (widx >= WIDX_W'(OFS_KEY0) && widx < WIDX_W'(OFS_KEY0 + KEY_WORDS)) begin
        dec_o.sel     = SEL_KEY;
        dec_o.key_idx = KIDX_W'(widx - WIDX_W'(OFS_KEY0));
      end else if (widx == WIDX_W'(OFS_STATUS)) dec_o.sel = SEL_STATUS;
      else if (widx == WIDX_W'(OFS_CTRL))  dec_o.sel = SEL_CTRL;
      else if (widx == WIDX_W'(OFS_MODE))  dec_o.sel = SEL_MODE;
      else if (widx == WIDX_W'(OFS_CRC))   dec_o.sel = SEL_CRC;
      else if (widx == WIDX_W'(OFS_ERREN)) dec_o.sel = SEL_ERREN;
      else if (widx == WIDX_W'(OFS_ISR))   dec_o.sel = SEL_ISR;
      else if (widx == WIDX_W'(OFS_IMR))   dec_o.sel = SEL_IMR;
      else if (widx == WIDX_W'(OFS_IEN))   dec_o.sel = SEL_IEN;
      else if (widx == WIDX_W'(OFS_IDIS))  dec_o.sel = SEL_IDIS;
      else if (widx == WIDX_W'(OFS_LOCK))  dec_o.sel = SEL_LOCK;
    end
  end
endmodule

// File: rtl/kv_keystore.sv
module kv_keystore
  import kv_pkg::*;
#(
  parameter bit W8_WO = 1'b0
) (
  input  logic                        clk,
  input  logic                        vault_rst,
  input  logic                        we_i,
  input  logic [KIDX_W-1:0]           idx_i,
  input  word_t                       wdata_i,
  input  logic                        zeroize_i,
  output logic [KEY_WORDS*BKV_W-1:0]  keys_o
);
  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    localparam bit WIPED = (g < CHK_WORDS) || W8_WO;
    word_t word_q;
    always_ff @(posedge clk) begin
      if (vault_rst)                                 word_q <= '0;
      else if (zeroize_i && WIPED)                   word_q <= '0;
      else if (we_i && idx_i == KIDX_W'(g))          word_q <= wdata_i;
    end
    assign keys_o[g*BKV_W +: BKV_W] = word_q;
  end

  AST_ZEROIZE_CLEARS_W0: assert property (@(posedge clk) disable iff (vault_rst)
    zeroize_i |=> (keys_o[BKV_W-1:0] == '0)); // R4
endmodule

// File: rtl/kv_crc_engine.sv
module kv_crc_engine
  import kv_pkg::*;
#(
  parameter word_t       POLY    = 32'h82F6_3B78,
  parameter int unsigned N_WORDS = CHK_WORDS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  word_t                     ref_i,
  input  logic [N_WORDS*BKV_W-1:0]  words_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      pass_o
);
  localparam int unsigned STEPS = N_WORDS + 1;   // zero word plus the key
  localparam int unsigned CNT_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0] cnt_q;
  word_t acc_q, ref_q, cur, acc_nxt;
  logic  busy_q, done_q, pass_q;

  always_comb begin
    cur = '0;
    for (int i = 0; i < N_WORDS; i++)
      if (cnt_q == CNT_W'(i + 1)) cur = words_i[i*BKV_W +: BKV_W];
  end

  assign acc_nxt = crc_fold(acc_q, cur, POLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      ref_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      ref_q  <= ref_i;
    end else if (busy_q) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(STEPS - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        pass_q <= (acc_nxt == ref_q);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign pass_o = pass_q;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q); // R9
  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    pass_q |-> done_q); // R9
endmodule

// File: rtl/kv_irq.sv
module kv_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic w1c_i,
  input  logic ien_i,
  input  logic idis_i,
  output logic isr_o,
  output logic imr_o,
  output logic irq_o
);
  logic isr_q, imr_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= 1'b0;
      imr_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (set_i)      isr_q <= 1'b1;
      else if (w1c_i) isr_q <= 1'b0;
      if (ien_i)       imr_q <= 1'b0;
      else if (idis_i) imr_q <= 1'b1;
      irq_q <= isr_q & ~imr_q;
    end
  end

  assign isr_o = isr_q;
  assign imr_o = imr_q;
  assign irq_o = irq_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> isr_q); // R11
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(isr_q)); // R12
endmodule

// File: rtl/keyvault_ctrl.sv
module keyvault_ctrl
  import kv_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] MODE_KEY  = 32'h757B_DF0D,
  parameter logic [31:0] CRC_POLY  = 32'h82F6_3B78,
  parameter bit          W8_WO     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vault_rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_err_o,
  output logic              bus_wait_o,
  output logic              irq_o
);
  localparam logic [KIDX_W-1:0] LAST_IDX = KIDX_W'(KEY_WORDS - 1);

  dec_t dec;
  kv_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(bus_addr_i), .dec_o(dec));

  logic busy, chk_done, chk_pass;
  logic mode_q, zeroed_q, lock_q, erren_q, err_q;
  word_t rdata_q, rd_val, key8;
  logic [KEY_WORDS*BKV_W-1:0] keys;
  logic isr, imr;

  // write qualification
  logic stallable, wr_do, is_w8;
  logic mode_hit, ctrl_zero, zeroize, key_we, crc_go, bad_acc, err_evt;

  assign stallable = (dec.sel == SEL_CTRL) || (dec.sel == SEL_MODE) ||
                     (dec.sel == SEL_CRC)  || (dec.sel == SEL_KEY);
  assign wr_do     = bus_wr_i && !rst && !(stallable && busy);
  assign is_w8     = (dec.key_idx == LAST_IDX);
  assign mode_hit  = wr_do && dec.sel == SEL_MODE && bus_wdata_i == MODE_KEY;
  assign ctrl_zero = wr_do && dec.sel == SEL_CTRL && bus_wdata_i[0];
  assign zeroize   = mode_hit || ctrl_zero;
  assign key_we    = wr_do && dec.sel == SEL_KEY && mode_q && (!is_w8 || !lock_q);
  assign crc_go    = wr_do && dec.sel == SEL_CRC && mode_q;
  assign bad_acc   = (bus_wr_i || bus_rd_i) && dec.sel == SEL_NONE;
  assign err_evt   = bad_acc && erren_q && !rst;

  kv_keystore #(.W8_WO(W8_WO)) u_store (
    .clk       (clk),
    .vault_rst (vault_rst),
    .we_i      (key_we),
    .idx_i     (dec.key_idx),
    .wdata_i   (bus_wdata_i),
    .zeroize_i (zeroize),
    .keys_o    (keys)
  );
  assign key8 = keys[KEY_WORDS*BKV_W-1 -: BKV_W];

  kv_crc_engine #(.POLY(CRC_POLY), .N_WORDS(CHK_WORDS)) u_crc (
    .clk     (clk),
    .rst     (rst),
    .start_i (crc_go),
    .ref_i   (bus_wdata_i),
    .words_i (keys[CHK_WORDS*BKV_W-1:0]),
    .busy_o  (busy),
    .done_o  (chk_done),
    .pass_o  (chk_pass)
  );

  kv_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_i  (err_evt),
    .w1c_i  (wr_do && dec.sel == SEL_ISR  && bus_wdata_i[0]),
    .ien_i  (wr_do && dec.sel == SEL_IEN  && bus_wdata_i[0]),
    .idis_i (wr_do && dec.sel == SEL_IDIS && bus_wdata_i[0]),
    .isr_o  (isr),
    .imr_o  (imr),
    .irq_o  (irq_o)
  );

  // control state; key words are not touched by rst
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      zeroed_q <= 1'b0;
      lock_q   <= 1'b0;
      erren_q  <= 1'b0;
    end else begin
      if (mode_hit) mode_q <= 1'b1;
      if (zeroize)
        zeroed_q <= 1'b1;
      else if (key_we && bus_wdata_i != '0 && (!is_w8 || W8_WO))
        zeroed_q <= 1'b0;
      if (wr_do && dec.sel == SEL_LOCK && bus_wdata_i[0] && !W8_WO)
        lock_q <= 1'b1;
      if (wr_do && dec.sel == SEL_ERREN)
        erren_q <= bus_wdata_i[0];
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (dec.sel)
      SEL_STATUS: begin
        rd_val[ST_MODE] = mode_q;
        rd_val[ST_ZERO] = zeroed_q;
        rd_val[ST_DONE] = chk_done;
        rd_val[ST_PASS] = chk_pass;
      end
      SEL_KEY:   rd_val = (is_w8 && !W8_WO) ? key8 : '0;
      SEL_ERREN: rd_val[0] = erren_q;
      SEL_ISR:   rd_val[0] = isr;
      SEL_IMR:   rd_val[0] = imr;
      SEL_LOCK:  rd_val[0] = lock_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_evt;
      if (bus_rd_i) rdata_q <= rd_val;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_err_o   = err_q;
  assign bus_wait_o  = busy;

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> mode_q); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q); // R8
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    bus_err_o |-> erren_q); // R11
  AST_W8_FROZEN: assert property (@(posedge clk) disable iff (rst || vault_rst)
    (lock_q && !zeroize) |=> $stable(key8)); // R7
endmodule

// File: tb/keyvault_ctrl_tb_top.sv
`timescale 1ns/1ps
module keyvault_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, vault_rst, wr, rd, tgt;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata_a, rdata_b;
  logic err_a, err_b, wait_a, wait_b, irq_a, irq_b;

  keyvault_ctrl dut_i (
    .clk(clk), .rst(rst), .vault_rst(vault_rst),
    .bus_wr_i(wr && !tgt), .bus_rd_i(rd && !tgt), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_a), .bus_err_o(err_a),
    .bus_wait_o(wait_a), .irq_o(irq_a));

  keyvault_ctrl #(.W8_WO(1'b1)) dut_wo_i (
    .clk(clk), .rst(rst), .vault_rst(vault_rst),
    .bus_wr_i(wr && tgt), .bus_rd_i(rd && tgt), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_b), .bus_err_o(err_b),
    .bus_wait_o(wait_b), .irq_o(irq_b));

  wire [31:0] rdata_cur = tgt ? rdata_b : rdata_a;
  wire        err_cur   = tgt ? err_b : err_a;
  wire        wait_cur  = tgt ? wait_b : wait_a;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit t, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tgt = t;
    #1;
    while (wait_cur) @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input bit t, input logic [7:0] a,
                          output logic [31:0] d, output logic e);
    @(negedge clk);
    tgt = t; addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata_cur; e = err_cur;
  endtask

  task automatic soft_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // {write, address, data or expected, requirement number}
  localparam int NV = 34;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0000_0000, 4'd1},   // R1 status
    {1'b0, 8'h3C, 32'h0000_0001, 4'd1},   // R1 mask
    {1'b0, 8'h4C, 32'h0000_0000, 4'd1},   // R1 lock
    {1'b1, 8'h10, 32'h1111_1111, 4'd5},
    {1'b1, 8'h30, 32'hA5A5_A5A5, 4'd7},   // R7 mode off
    {1'b0, 8'h30, 32'h0000_0000, 4'd7},
    {1'b1, 8'h08, 32'h1234_5678, 4'd2},   // R2 wrong key
    {1'b0, 8'h00, 32'h0000_0000, 4'd2},
    {1'b1, 8'h08, 32'h757B_DF0D, 4'd2},
    {1'b0, 8'h00, 32'h0000_0011, 4'd2},
    {1'b1, 8'h10, 32'h0000_0000, 4'd6},   // R6 zero write
    {1'b0, 8'h00, 32'h0000_0011, 4'd6},
    {1'b1, 8'h30, 32'hCAFE_F00D, 4'd7},
    {1'b0, 8'h00, 32'h0000_0011, 4'd6},   // R6 word 8 readable mode
    {1'b0, 8'h30, 32'hCAFE_F00D, 4'd7},
    {1'b1, 8'h14, 32'hDEAD_BEEF, 4'd6},
    {1'b0, 8'h00, 32'h0000_0001, 4'd6},
    {1'b0, 8'h14, 32'h0000_0000, 4'd5},   // R5 key reads zero
    {1'b0, 8'h0C, 32'h0000_0000, 4'd5},
    {1'b1, 8'h04, 32'h0000_0001, 4'd3},   // R3 zeroize
    {1'b0, 8'h00, 32'h0000_0011, 4'd3},
    {1'b0, 8'h04, 32'h0000_0000, 4'd3},
    {1'b0, 8'h30, 32'hCAFE_F00D, 4'd4},   // R4 word 8 kept
    {1'b1, 8'h08, 32'h0000_0000, 4'd2},
    {1'b0, 8'h00, 32'h0000_0011, 4'd2},
    {1'b1, 8'h00, 32'hFFFF_FFFF, 4'd13},  // R13 read-only status
    {1'b0, 8'h00, 32'h0000_0011, 4'd13},
    {1'b1, 8'h4C, 32'h0000_0001, 4'd8},   // R8
    {1'b0, 8'h4C, 32'h0000_0001, 4'd8},
    {1'b1, 8'h4C, 32'h0000_0000, 4'd8},
    {1'b0, 8'h4C, 32'h0000_0001, 4'd8},
    {1'b1, 8'h30, 32'h0000_0001, 4'd7},   // R7 locked
    {1'b0, 8'h30, 32'hCAFE_F00D, 4'd7},
    {1'b0, 8'h34, 32'h0000_0000, 4'd11}
  };

  logic [31:0] kv [8];

  function automatic logic [31:0] ref_crc();
    logic [31:0] c, w;
    logic fb;
    c = '0;
    for (int i = 0; i < 9; i++) begin
      w = (i == 0) ? 32'h0 : kv[i-1];
      for (int b = 0; b < 32; b++) begin
        fb = c[0] ^ w[b];
        c = c >> 1;
        if (fb) c = c ^ 32'h82F6_3B78;
      end
    end
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, good;
    logic e;
    int n;
    rst = 1'b1; vault_rst = 1'b1; wr = 1'b0; rd = 1'b0; tgt = 1'b0;
    addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0; vault_rst = 1'b0;
    check("R1 irq", {31'b0, irq_a}, 32'h0);
    check("R1 wait", {31'b0, wait_a}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) bus_write(1'b0, VEC[i][43:36], VEC[i][35:4]);
      else begin
        bus_read(1'b0, VEC[i][43:36], d, e);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), d, VEC[i][35:4]);
      end
    end

    // R13 soft reset keeps keys
    soft_reset();
    bus_read(1'b0, 8'h00, d, e); check("R13 status", d, 32'h0);
    bus_read(1'b0, 8'h4C, d, e); check("R13 lock", d, 32'h0);
    bus_read(1'b0, 8'h3C, d, e); check("R13 mask", d, 32'h1);
    bus_read(1'b0, 8'h30, d, e); check("R13 key kept", d, 32'hCAFE_F00D);

    // R9 check outside programming mode
    bus_write(1'b0, 8'h0C, 32'h0);
    check("R9 no start", {31'b0, wait_a}, 32'h0);
    bus_read(1'b0, 8'h00, d, e); check("R9 no done", d, 32'h0);

    bus_write(1'b0, 8'h08, 32'h757B_DF0D);
    for (int i = 0; i < 8; i++) begin
      kv[i] = 32'h9E37_79B9 * (i + 1);
      bus_write(1'b0, 8'(8'h10 + 4*i), kv[i]);
    end
    good = ref_crc();
    bus_write(1'b0, 8'h0C, good);
    n = 0;
    while (wait_a && n < 50) begin n++; @(negedge clk); end
    check("R9 busy cycles", n, 9);
    bus_read(1'b0, 8'h00, d, e); check("R9 pass", d, 32'h0000_0301);

    bus_write(1'b0, 8'h0C, good ^ 32'h1);
    check("R10 wait high", {31'b0, wait_a}, 32'h1);
    addr = 8'h30; wdata = 32'h0BAD_BEEF; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    while (wait_a) @(negedge clk);
    bus_read(1'b0, 8'h00, d, e); check("R9 mismatch", d, 32'h0000_0101);
    bus_read(1'b0, 8'h30, d, e); check("R10 write held off", d, 32'hCAFE_F00D);

    // R11 / R12 error reporting and interrupt
    bus_read(1'b0, 8'h48, d, e); check("R11 no err when disabled", {31'b0, e}, 32'h0);
    bus_read(1'b0, 8'h38, d, e); check("R11 no isr when disabled", d, 32'h0);
    bus_write(1'b0, 8'h34, 32'h1);
    bus_read(1'b0, 8'h48, d, e); check("R11 err", {31'b0, e}, 32'h1);
    bus_read(1'b0, 8'h38, d, e); check("R11 isr set", d, 32'h1);
    check("R12 masked", {31'b0, irq_a}, 32'h0);
    bus_write(1'b0, 8'h3C, 32'h0);
    bus_read(1'b0, 8'h3C, d, e); check("R12 mask read-only", d, 32'h1);
    bus_write(1'b0, 8'h40, 32'h1);
    @(negedge clk);
    check("R12 irq raised", {31'b0, irq_a}, 32'h1);
    bus_read(1'b0, 8'h3C, d, e); check("R12 unmasked", d, 32'h0);
    bus_write(1'b0, 8'h38, 32'h0);
    bus_read(1'b0, 8'h38, d, e); check("R12 w1c zero", d, 32'h1);
    bus_write(1'b0, 8'h38, 32'h1);
    @(negedge clk);
    bus_read(1'b0, 8'h38, d, e); check("R12 w1c", d, 32'h0);
    check("R12 irq low", {31'b0, irq_a}, 32'h0);
    bus_read(1'b0, 8'h11, d, e); check("R11 unaligned", {31'b0, e}, 32'h1);
    bus_write(1'b0, 8'h44, 32'h1);
    bus_read(1'b0, 8'h3C, d, e); check("R12 disable", d, 32'h1);

    // write-only variant
    bus_write(1'b1, 8'h08, 32'h757B_DF0D);
    bus_read(1'b1, 8'h00, d, e); check("R4 wo zeroized", d, 32'h11);
    bus_write(1'b1, 8'h30, 32'h0000_0055);
    bus_read(1'b1, 8'h30, d, e); check("R7 wo reads zero", d, 32'h0);
    bus_read(1'b1, 8'h00, d, e); check("R6 wo word 8 clears flag", d, 32'h01);
    bus_write(1'b1, 8'h4C, 32'h1);
    bus_read(1'b1, 8'h4C, d, e); check("R8 wo never locks", d, 32'h0);
    bus_write(1'b1, 8'h04, 32'h1);
    bus_read(1'b1, 8'h00, d, e); check("R3 wo ctrl zeroize", d, 32'h11);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule